// File: doc/BRIEF.md
# Reversible-Cell Ripple Adder/Subtractor

This block adds or subtracts two unsigned operands with a ripple carry chain in which every bit position is a small reversible cell. Each cell is built only from controlled-NOT gates, which map (a, b) to (a, a xor b), and three-input Peres gates, which map (a, b, c) to (a, a xor b, (a and b) xor c). One mode bit selects the operation: 0 adds, 1 subtracts. The mode bit is not applied once to the B operand with a forced carry-in. Instead, every cell takes the mode bit and uses controlled-NOT gates to flip its own A input on the way in and to flip its sum bit on the way out. The same cell structure therefore yields a sum and carry in one mode and a difference and borrow in the other.

Bit 0 is a half cell: two controlled-NOT gates, one Peres gate, one constant-zero line and two garbage lines. Every higher bit is a full cell: two controlled-NOT gates, two Peres gates, one constant-zero line and three garbage lines. The carry or borrow of each stage feeds the next stage. The top stage drives a separate carry/borrow output. All garbage lines of all cells are gathered into one bus, because a reversible circuit has to keep them. The result, the carry/borrow and the garbage bus are registered on the rising clock edge, and a synchronous active-high reset clears them.

Top module: `revcell_addsub`

## Requirements
- R1: While `rst` is high at a rising edge, that edge clears `sum_diff`, `cb_out` and `junk_bus` to zero.
- R2: With `sub_mode` = 0, the edge after the operands are presented gives `sum_diff` = (`opnd_a` + `opnd_b`) mod 2^WIDTH, and `cb_out` equals bit WIDTH of the full sum.
- R3: With `sub_mode` = 1, the edge after the operands are presented gives `sum_diff` = (`opnd_a` − `opnd_b`) mod 2^WIDTH, and `cb_out` = 1 exactly when `opnd_a` < `opnd_b`.
- R4: Only the input values present at a rising edge set the outputs after that edge. Input changes between edges have no effect on the result.
- R5: The garbage lines of the bit-0 half cell sit at `junk_bus[0]` = `opnd_a[0]` xor `sub_mode` and `junk_bus[1]` = `sub_mode`.
- R6: The garbage lines of full cell i (1 ≤ i < WIDTH) sit at base index 3i−1. Bit base+0 holds `opnd_a[i]` xor `sub_mode`. Bit base+1 holds `opnd_a[i]` xor `sub_mode` xor `opnd_b[i]`. Bit base+2 holds `sub_mode`.
- R7: A carry or borrow travels through every stage: all-ones + 1 gives zero with `cb_out` = 1, and 0 − 1 gives all-ones with `cb_out` = 1.
- R8: Subtracting equal operands gives zero with `cb_out` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opnd_a | input | WIDTH | First operand (minuend in subtract mode) |
| opnd_b | input | WIDTH | Second operand (subtrahend in subtract mode) |
| sub_mode | input | 1 | 0 = add, 1 = subtract |
| sum_diff | output | WIDTH | Registered sum or difference |
| cb_out | output | 1 | Registered carry (add) or borrow (subtract) from the top stage |
| junk_bus | output | 3*WIDTH-1 | Registered garbage lines of all cells |

## Verification
Directed pairs such as 0xAE + 0x57 separate a correct carry chain from one that drops the top carry. An 8-by-8 grid of corner values (0, 1, 0x7F, 0x80, 0xFE, 0xFF, 0x55, 0xAA) run in both modes separates borrow polarity from carry polarity, and it catches a cell whose mode flip is missing on only one side. All-ones plus one and zero minus one drive the carry or borrow through every stage. Equal operands in subtract mode isolate borrow generation from propagation. Several hundred pseudo-random pairs, operands changed in mid-cycle, and a check of every garbage line against its closed form together catch a swapped gate input inside a cell.

// File: rtl/revcell_pkg.sv
package revcell_pkg;

  // Controlled-NOT: (a, b) -> (a, a ^ b)
  typedef struct packed {
    logic p;
    logic q;
  } cnot_out_t;

  // Peres: (a, b, c) -> (a, a ^ b, (a & b) ^ c)
  typedef struct packed {
    logic p;
    logic q;
    logic r;
  } peres_out_t;

  function automatic cnot_out_t cnot_gate(input logic a, input logic b);
    cnot_out_t o;
    o.p = a;
    o.q = a ^ b;
    return o;
  endfunction

  function automatic peres_out_t peres_gate(input logic a, input logic b, input logic c);
    peres_out_t o;
    o.p = a;
    o.q = a ^ b;
    o.r = (a & b) ^ c;
    return o;
  endfunction

  localparam int HALF_JUNK = 2;
  localparam int FULL_JUNK = 3;

  function automatic int junk_width(input int w);
    return HALF_JUNK + FULL_JUNK * (w - 1);
  endfunction

endpackage

// File: rtl/rc_half_cell.sv
module rc_half_cell
  import revcell_pkg::*;
(
  input  logic       a,
  input  logic       b,
  input  logic       ctrl,
  output logic       sd,
  output logic       cb,
  output logic [1:0] junk
);

  cnot_out_t  g_in;
  peres_out_t g_pg;
  cnot_out_t  g_out;
  logic       zero_line;

  assign zero_line = 1'b0;

  always_comb begin
    // conditionally invert a on the way in
    g_in  = cnot_gate(ctrl, a);
    // half add of (a^ctrl, b) on a constant-zero line
    g_pg  = peres_gate(g_in.q, b, zero_line);
    // undo the inversion on the sum/difference line
    g_out = cnot_gate(g_in.p, g_pg.q);
  end

  assign sd   = g_out.q;
  assign cb   = g_pg.r;
  assign junk = {g_out.p, g_pg.p};

endmodule

// File: rtl/rc_full_cell.sv
module rc_full_cell
  import revcell_pkg::*;
(
  input  logic       a,
  input  logic       b,
  input  logic       cin,
  input  logic       ctrl,
  output logic       sd,
  output logic       cb,
  output logic [2:0] junk
);

  cnot_out_t  g_in;
  peres_out_t g_pg1;
  peres_out_t g_pg2;
  cnot_out_t  g_out;
  logic       zero_line;

  assign zero_line = 1'b0;

  always_comb begin
    g_in  = cnot_gate(ctrl, a);
    // first Peres: generate term on the constant line
    g_pg1 = peres_gate(g_in.q, b, zero_line);
    // second Peres: fold in the incoming carry/borrow
    g_pg2 = peres_gate(g_pg1.q, cin, g_pg1.r);
    g_out = cnot_gate(g_in.p, g_pg2.q);
  end

  assign sd   = g_out.q;
  assign cb   = g_pg2.r;
  assign junk = {g_out.p, g_pg2.p, g_pg1.p};

endmodule

// File: rtl/rc_ripple_chain.sv
module rc_ripple_chain
  import revcell_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int JW   = junk_width(WIDTH)
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             ctrl,
  output logic [WIDTH-1:0] sd,
  output logic             cb_top,
  output logic [JW-1:0]    junk
);

  logic [WIDTH:1] cy;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == 0) begin : g_half
      rc_half_cell u_cell (
        .a    (a[0]),
        .b    (b[0]),
        .ctrl (ctrl),
        .sd   (sd[0]),
        .cb   (cy[1]),
        .junk (junk[HALF_JUNK-1:0])
      );
    end else begin : g_full
      localparam int BASE = HALF_JUNK + FULL_JUNK * (i - 1);
      rc_full_cell u_cell (
        .a    (a[i]),
        .b    (b[i]),
        .cin  (cy[i]),
        .ctrl (ctrl),
        .sd   (sd[i]),
        .cb   (cy[i+1]),
        .junk (junk[BASE +: FULL_JUNK])
      );
    end
  end

  assign cb_top = cy[WIDTH];

endmodule

// File: rtl/revcell_addsub.sv
module revcell_addsub
  import revcell_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int JW   = junk_width(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic             sub_mode,
  output logic [WIDTH-1:0] sum_diff,
  output logic             cb_out,
  output logic [JW-1:0]    junk_bus
);

  logic [WIDTH-1:0] chain_sd;
  logic             chain_cb;
  logic [JW-1:0]    chain_junk;

  rc_ripple_chain #(.WIDTH(WIDTH)) u_chain (
    .a      (opnd_a),
    .b      (opnd_b),
    .ctrl   (sub_mode),
    .sd     (chain_sd),
    .cb_top (chain_cb),
    .junk   (chain_junk)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_diff <= '0;
      cb_out   <= 1'b0;
      junk_bus <= '0;
    end else begin
      sum_diff <= chain_sd;
      cb_out   <= chain_cb;
      junk_bus <= chain_junk;
    end
  end

endmodule

// File: rtl/revcell_addsub_checker.sv
module revcell_addsub_checker
  import revcell_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int JW   = junk_width(WIDTH)
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic             sub_mode,
  input logic [WIDTH-1:0] sum_diff,
  input logic             cb_out,
  input logic [JW-1:0]    junk_bus
);

  logic armed;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b1;
  end

  // R1: the edge after reset leaves every output cleared
  assert_reset_clear_R1: assert property (@(posedge clk)
    armed && $past(rst) |-> (sum_diff == '0 && !cb_out && junk_bus == '0));

  // R2 and R4: add result comes from the operands sampled at the last edge
  assert_add_result_R2: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(rst) && !$past(sub_mode) |->
      {cb_out, sum_diff} == ({1'b0, $past(opnd_a)} + {1'b0, $past(opnd_b)}));

  // R3: difference and borrow
  assert_sub_result_R3: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(rst) && $past(sub_mode) |->
      (sum_diff == WIDTH'($past(opnd_a) - $past(opnd_b)) &&
       cb_out == ($past(opnd_a) < $past(opnd_b))));

  // R5: half-cell garbage lines
  assert_half_junk_R5: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(rst) |->
      (junk_bus[0] == ($past(opnd_a[0]) ^ $past(sub_mode)) &&
       junk_bus[1] == $past(sub_mode)));

  // R6: full-cell garbage lines
  for (genvar i = 1; i < WIDTH; i++) begin : g_junk_chk
    localparam int BASE = HALF_JUNK + FULL_JUNK * (i - 1);
    assert_full_junk_R6: assert property (@(posedge clk) disable iff (rst)
      armed && !$past(rst) |->
        (junk_bus[BASE]   == ($past(opnd_a[i]) ^ $past(sub_mode)) &&
         junk_bus[BASE+1] == ($past(opnd_a[i]) ^ $past(sub_mode) ^ $past(opnd_b[i])) &&
         junk_bus[BASE+2] == $past(sub_mode)));
  end

  // R8: equal operands in subtract mode never borrow
  assert_equal_sub_R8: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(rst) && $past(sub_mode) && ($past(opnd_a) == $past(opnd_b)) |->
      (sum_diff == '0 && !cb_out));

endmodule

bind revcell_addsub revcell_addsub_checker #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .opnd_a   (opnd_a),
  .opnd_b   (opnd_b),
  .sub_mode (sub_mode),
  .sum_diff (sum_diff),
  .cb_out   (cb_out),
  .junk_bus (junk_bus)
);

// File: tb/revcell_addsub_bench.sv
`timescale 1ns/1ps
module revcell_addsub_bench;

  localparam int W  = 8;
  localparam int JW = 3 * W - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  a = '0;
  logic [W-1:0]  b = '0;
  logic          s = 1'b0;
  logic [W-1:0]  res;
  logic          co;
  logic [JW-1:0] junk;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  revcell_addsub #(.WIDTH(W)) u_revcell_addsub (
    .clk      (clk),
    .rst      (rst),
    .opnd_a   (a),
    .opnd_b   (b),
    .sub_mode (s),
    .sum_diff (res),
    .cb_out   (co),
    .junk_bus (junk)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [JW-1:0] junk_model(input logic [W-1:0] x, input logic [W-1:0] y, input logic m);
    logic [JW-1:0] j;
    j[0] = x[0] ^ m;
    j[1] = m;
    for (int i = 1; i < W; i++) begin
      j[3*i-1] = x[i] ^ m;
      j[3*i]   = x[i] ^ m ^ y[i];
      j[3*i+1] = m;
    end
    return j;
  endfunction

  // present one operation, sample one cycle later at the falling edge
  task automatic run_op(input logic [W-1:0] x, input logic [W-1:0] y, input logic m, input string req);
    logic [W:0]   full;
    logic [W-1:0] er;
    logic         ec;
    @(negedge clk);
    a = x; b = y; s = m;
    @(negedge clk);
    if (!m) begin
      full = {1'b0, x} + {1'b0, y};
      er = full[W-1:0];
      ec = full[W];
    end else begin
      er = x - y;
      ec = (x < y);
    end
    chk({co, res} == {ec, er}, req, 32'({co, res}), 32'({ec, er}));
    chk(junk == junk_model(x, y, m), "R5 R6 garbage lines", 32'(junk), 32'(junk_model(x, y, m)));
  endtask

  task automatic t_reset_start();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(res == '0 && !co && junk == '0, "R1 reset state", 32'({junk, co, res}), 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_reset_midrun();
    run_op(8'hFF, 8'hFF, 1'b0, "R2 before reset");
    @(negedge clk);
    rst = 1'b1; a = 8'hAA; b = 8'h0F; s = 1'b1;
    @(negedge clk);
    chk(res == '0 && !co && junk == '0, "R1 reset mid-run", 32'({junk, co, res}), 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_add_directed();
    run_op(8'h09, 8'h03, 1'b0, "R2 add small");
    run_op(8'hAE, 8'h57, 1'b0, "R2 add with carry");
    run_op(8'h00, 8'h00, 1'b0, "R2 add zero");
    run_op(8'h80, 8'h80, 1'b0, "R2 add top bits");
  endtask

  task automatic t_sub_directed();
    run_op(8'h30, 8'h11, 1'b1, "R3 sub no borrow");
    run_op(8'h11, 8'h30, 1'b1, "R3 sub borrow");
    run_op(8'hFF, 8'h00, 1'b1, "R3 sub zero subtrahend");
    run_op(8'h80, 8'h7F, 1'b1, "R3 sub across middle");
  endtask

  task automatic t_ripple_R7();
    run_op(8'hFF, 8'h01, 1'b0, "R7 full carry ripple");
    run_op(8'h00, 8'h01, 1'b1, "R7 full borrow ripple");
    run_op(8'h7F, 8'h01, 1'b0, "R7 ripple to top bit");
  endtask

  task automatic t_equal_R8();
    logic [W-1:0] vals [4] = '{8'h00, 8'h5A, 8'hFF, 8'h80};
    for (int k = 0; k < 4; k++) run_op(vals[k], vals[k], 1'b1, "R8 equal operands");
  endtask

  task automatic t_corner_grid();
    logic [W-1:0] cv [8] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFE, 8'hFF, 8'h55, 8'hAA};
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          run_op(cv[i], cv[j], m[0], m[0] ? "R3 corner grid" : "R2 corner grid");
  endtask

  task automatic t_random();
    for (int k = 0; k < 400; k++) begin
      logic [W-1:0] x, y;
      logic m;
      x = W'($urandom);
      y = W'($urandom);
      m = 1'($urandom);
      run_op(x, y, m, m ? "R3 random" : "R2 random");
    end
  endtask

  // inputs changed between edges: only the value at the edge counts
  task automatic t_midcycle_R4();
    @(negedge clk);
    a = 8'h12; b = 8'hEE; s = 1'b1;
    #0.5 a = 8'hC3; b = 8'h3C; s = 1'b0;
    #0.5 a = 8'h40; b = 8'h05; s = 1'b1;
    @(negedge clk);
    chk({co, res} == {1'b0, 8'h3B}, "R4 mid-cycle changes", 32'({co, res}), 32'h3B);
    #0.5 a = 8'hFF; b = 8'hFF; s = 1'b0;
    #1.0;
    chk({co, res} == {1'b0, 8'h3B}, "R4 hold between edges", 32'({co, res}), 32'h3B);
  endtask

  initial begin
    t_reset_start();
    t_add_directed();
    t_sub_directed();
    t_ripple_R7();
    t_equal_R8();
    t_midcycle_R4();
    t_corner_grid();
    t_random();
    t_reset_midrun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule